// File: doc/BRIEF.md
# Paired-Accumulator Multiply-Accumulate Unit

This block is a 32-bit multiply-accumulate engine with two fixed 32-bit result registers: a high word and a low word. Each operation is started with a one-cycle `start_i` strobe together with a 4-bit operation code and two 32-bit operands. Single-word operations update only the low word. Double-word operations treat the two registers as one 64-bit accumulator, with the high word holding bits 63:32.

The unit offers these operations:

- a truncated product;
- full unsigned and signed 64-bit products;
- signed multiply-add and multiply-subtract, each in 32-bit and 64-bit forms;
- a signed dual half-word dot product that accumulates into 32 or 64 bits.

Arithmetic wraps with no saturation, and the unit keeps no condition flags. A synchronous load port writes both registers directly, and it wins over an operation started in the same cycle. Both registers are always visible on the outputs.

Each result is written at the clock edge that samples `start_i`. `done_o` is high for the cycle that follows, and the new register values are visible in that same cycle. The asynchronous active-low reset is released through a two-stage synchronizer.

Top module: `mac_pair_unit`

## Requirements
- R1: While reset is asserted, and after it is released, both accumulator words read zero and `done_o` is low.
- R2: Op code 0 writes bits 31:0 of A*B to the low word; the high word is unchanged (the result is the same for signed and unsigned operands).
- R3: Op code 1 writes the full unsigned 64-bit product A*B to the pair, with the high word holding bits 63:32.
- R4: Op code 2 writes the full signed (two's complement) 64-bit product A*B to the pair.
- R5: Op codes 3 and 5 set the low word to low + A*B and low − A*B respectively, with A and B signed, modulo 2^32; the high word is unchanged.
- R6: Op codes 4 and 6 set the 64-bit pair to pair + A*B and pair − A*B respectively, with A and B signed, modulo 2^64.
- R7: Op code 7 adds A[31:16]*B[31:16] + A[15:0]*B[15:0] to the low word, with the half-words signed, modulo 2^32; the high word is unchanged.
- R8: Op code 8 adds the same signed half-word dot product, sign-extended to 64 bits, to the pair, modulo 2^64.
- R9: `done_o` is high in exactly the cycle after each accepted start (start without load), and the result is visible on the outputs in that cycle.
- R10: With `load_i` high, the high and low words take `load_hi_i` and `load_lo_i` at the clock edge; a start in the same cycle is discarded and raises no `done_o`.
- R11: Op codes 9 to 15 leave both words unchanged but still produce a `done_o` pulse.
- R12: In a cycle with neither start nor load, both words hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start_i | input | 1 | Starts the operation given by `op_i` |
| op_i | input | 4 | Operation code (see R2 to R11) |
| a_i | input | 32 | Operand A |
| b_i | input | 32 | Operand B |
| load_i | input | 1 | Direct write of both accumulator words |
| load_hi_i | input | 32 | Value loaded into the high word |
| load_lo_i | input | 32 | Value loaded into the low word |
| done_o | output | 1 | One-cycle completion pulse |
| acc_hi_o | output | 32 | High accumulator word |
| acc_lo_o | output | 32 | Low accumulator word |

## Verification
On every cycle, the assertions check the control behaviour:

- the timing of the done pulse;
- that a load wins over a start;
- that single-word operations leave the high word untouched;
- that both words hold in idle cycles.

They do not model the arithmetic. The bench sweeps every op code over a grid of corner operands (zero, one, all-ones, the extreme signed values and mixed half-word signs) on top of preloaded accumulators that force carries and borrows across bit 32. It compares each result with a product computed separately in 64-bit arithmetic. Only those sweeps show that the signed, unsigned and half-word products, and the wrap-around, are correct.

// File: rtl/mac_pkg.sv
package mac_pkg;

  typedef enum logic [3:0] {
    OP_MUL_LO  = 4'd0,
    OP_MULU_D  = 4'd1,
    OP_MULS_D  = 4'd2,
    OP_MAC_S   = 4'd3,
    OP_MAC_D   = 4'd4,
    OP_MSUB_S  = 4'd5,
    OP_MSUB_D  = 4'd6,
    OP_HMAC_S  = 4'd7,
    OP_HMAC_D  = 4'd8
  } mac_op_e;

  localparam int unsigned OP_W = 4;

endpackage

// File: rtl/mac_rst_sync.sv
module mac_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sn = sync_q[STAGES-1];

endmodule

// File: rtl/mac_mult.sv
module mac_mult #(
  parameter int unsigned DW = 32,
  parameter int unsigned HW = DW / 2
) (
  input  logic [DW-1:0]   a_i,
  input  logic [DW-1:0]   b_i,
  input  logic            signed_i,
  input  logic            half_i,
  output logic [2*DW-1:0] prod_o
);

  localparam int unsigned LANES = DW / HW;
  localparam int unsigned PW    = 2 * DW;

  logic [PW-1:0] a_ext;
  logic [PW-1:0] b_ext;
  logic [PW-1:0] full_prod;
  logic [PW-1:0] lane_prod [LANES];
  logic [PW-1:0] dot_sum;

  // Full-width product: extend by sign or zero, then a modulo-2^64 multiply
  always_comb begin
    a_ext     = {{DW{signed_i & a_i[DW-1]}}, a_i};
    b_ext     = {{DW{signed_i & b_i[DW-1]}}, b_i};
    full_prod = a_ext * b_ext;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic signed [HW-1:0] la;
    logic signed [HW-1:0] lb;
    logic signed [PW-1:0] lp;
    always_comb begin
      la = a_i[g*HW +: HW];
      lb = b_i[g*HW +: HW];
      lp = PW'(la) * PW'(lb);
      lane_prod[g] = lp;
    end
  end

  always_comb begin
    dot_sum = '0;
    for (int k = 0; k < LANES; k++) begin
      dot_sum = dot_sum + lane_prod[k];
    end
  end

  assign prod_o = half_i ? dot_sum : full_prod;

endmodule

// File: rtl/mac_accum.sv
module mac_accum
  import mac_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic [OP_W-1:0] op_i,
  input  logic [2*DW-1:0] prod_i,
  input  logic [DW-1:0]   hi_i,
  input  logic [DW-1:0]   lo_i,
  output logic [DW-1:0]   nxt_hi_o,
  output logic [DW-1:0]   nxt_lo_o,
  output logic            wr_hi_o,
  output logic            wr_lo_o
);

  logic [2*DW-1:0] acc;
  logic [2*DW-1:0] sum;
  logic [2*DW-1:0] dif;
  logic [2*DW-1:0] res;

  always_comb begin
    acc     = {hi_i, lo_i};
    sum     = acc + prod_i;
    dif     = acc - prod_i;
    res     = acc;
    wr_hi_o = 1'b0;
    wr_lo_o = 1'b0;
    unique case (op_i)
      OP_MUL_LO: begin res = prod_i; wr_lo_o = 1'b1; end
      OP_MULU_D,
      OP_MULS_D: begin res = prod_i; wr_hi_o = 1'b1; wr_lo_o = 1'b1; end
      OP_MAC_S,
      OP_HMAC_S: begin res = sum;    wr_lo_o = 1'b1; end
      OP_MAC_D,
      OP_HMAC_D: begin res = sum;    wr_hi_o = 1'b1; wr_lo_o = 1'b1; end
      OP_MSUB_S: begin res = dif;    wr_lo_o = 1'b1; end
      OP_MSUB_D: begin res = dif;    wr_hi_o = 1'b1; wr_lo_o = 1'b1; end
      default:   begin res = acc; end
    endcase
    nxt_hi_o = res[2*DW-1:DW];
    nxt_lo_o = res[DW-1:0];
  end

  // A double-word write always covers the low word as well
  always_comb begin
    AST_HI_IMPLIES_LO: assert (!wr_hi_o || wr_lo_o); // R6
  end

endmodule

// File: rtl/mac_pair_unit.sv
module mac_pair_unit
  import mac_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic [3:0]      op_i,
  input  logic [DW-1:0]   a_i,
  input  logic [DW-1:0]   b_i,
  input  logic            load_i,
  input  logic [DW-1:0]   load_hi_i,
  input  logic [DW-1:0]   load_lo_i,
  output logic            done_o,
  output logic [DW-1:0]   acc_hi_o,
  output logic [DW-1:0]   acc_lo_o
);

  logic            rst_sn;
  logic            half_sel;
  logic            signed_sel;
  logic [2*DW-1:0] prod;
  logic [DW-1:0]   op_hi, op_lo;
  logic            op_wr_hi, op_wr_lo;
  logic            accept;
  logic [DW-1:0]   hi_q, lo_q, hi_d, lo_d;
  logic            hi_en, lo_en;
  logic            done_q, done_d;

  mac_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_sn (rst_sn)
  );

  assign half_sel   = (op_i == OP_HMAC_S) || (op_i == OP_HMAC_D);
  assign signed_sel = (op_i != OP_MULU_D);

  mac_mult #(.DW(DW)) u_mult (
    .a_i      (a_i),
    .b_i      (b_i),
    .signed_i (signed_sel),
    .half_i   (half_sel),
    .prod_o   (prod)
  );

  mac_accum #(.DW(DW)) u_accum (
    .op_i     (op_i),
    .prod_i   (prod),
    .hi_i     (hi_q),
    .lo_i     (lo_q),
    .nxt_hi_o (op_hi),
    .nxt_lo_o (op_lo),
    .wr_hi_o  (op_wr_hi),
    .wr_lo_o  (op_wr_lo)
  );

  // Next-state: load has priority over an operation
  always_comb begin
    accept = start_i & ~load_i;
    done_d = accept;
    hi_en  = load_i | (accept & op_wr_hi);
    lo_en  = load_i | (accept & op_wr_lo);
    hi_d   = load_i ? load_hi_i : op_hi;
    lo_d   = load_i ? load_lo_i : op_lo;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      hi_q   <= '0;
      lo_q   <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= done_d;
      if (hi_en) hi_q <= hi_d;
      if (lo_en) lo_q <= lo_d;
    end
  end

  assign done_o   = done_q;
  assign acc_hi_o = hi_q;
  assign acc_lo_o = lo_q;

  AST_DONE_TIMING: assert property (@(posedge clk) disable iff (!rst_sn)
    1'b1 |=> (done_o == $past(start_i && !load_i))); // R9

  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_sn)
    load_i |=> (acc_hi_o == $past(load_hi_i)) && (acc_lo_o == $past(load_lo_i)) && !done_o); // R10

  AST_SINGLE_KEEPS_HI: assert property (@(posedge clk) disable iff (!rst_sn)
    (start_i && !load_i && (op_i == OP_MUL_LO || op_i == OP_MAC_S ||
     op_i == OP_MSUB_S || op_i == OP_HMAC_S)) |=> $stable(acc_hi_o)); // R5

  AST_UNUSED_OP_HOLDS: assert property (@(posedge clk) disable iff (!rst_sn)
    (start_i && !load_i && op_i > 4'd8) |=> $stable(acc_hi_o) && $stable(acc_lo_o)); // R11

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_sn)
    (!start_i && !load_i) |=> $stable(acc_hi_o) && $stable(acc_lo_o) && !done_o); // R12

endmodule

// File: tb/mac_pair_unit_tb.sv
`timescale 1ns/1ps
module mac_pair_unit_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i;
  logic [3:0]  op_i;
  logic [31:0] a_i, b_i;
  logic        load_i;
  logic [31:0] load_hi_i, load_lo_i;
  logic        done_o;
  logic [31:0] acc_hi_o, acc_lo_o;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  mac_pair_unit u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i),
    .a_i(a_i), .b_i(b_i), .load_i(load_i), .load_hi_i(load_hi_i),
    .load_lo_i(load_lo_i), .done_o(done_o), .acc_hi_o(acc_hi_o),
    .acc_lo_o(acc_lo_o)
  );

  logic [31:0] vals [8] = '{32'h0000_0000, 32'h0000_0001, 32'hFFFF_FFFF,
                            32'h8000_0000, 32'h7FFF_FFFF, 32'h8000_7FFF,
                            32'h7FFF_8000, 32'h1234_ABCD};

  function automatic logic [63:0] model(input logic [3:0] op, input logic [31:0] a,
                                        input logic [31:0] b, input logic [63:0] acc);
    logic [63:0] up, sp, dot, p1, p0;
    up  = {32'b0, a} * {32'b0, b};
    sp  = {{32{a[31]}}, a} * {{32{b[31]}}, b};
    p1  = {{48{a[31]}}, a[31:16]} * {{48{b[31]}}, b[31:16]};
    p0  = {{48{a[15]}}, a[15:0]} * {{48{b[15]}}, b[15:0]};
    dot = p1 + p0;
    case (op)
      4'd0: model = {acc[63:32], up[31:0]};
      4'd1: model = up;
      4'd2: model = sp;
      4'd3: model = {acc[63:32], acc[31:0] + sp[31:0]};
      4'd4: model = acc + sp;
      4'd5: model = {acc[63:32], acc[31:0] - sp[31:0]};
      4'd6: model = acc - sp;
      4'd7: model = {acc[63:32], acc[31:0] + dot[31:0]};
      4'd8: model = acc + dot;
      default: model = acc;
    endcase
  endfunction

  function automatic string req_of(input logic [3:0] op);
    case (op)
      4'd0: req_of = "R2";
      4'd1: req_of = "R3";
      4'd2: req_of = "R4";
      4'd3, 4'd5: req_of = "R5";
      4'd4, 4'd6: req_of = "R6";
      4'd7: req_of = "R7";
      4'd8: req_of = "R8";
      default: req_of = "R11";
    endcase
  endfunction

  task automatic check(input string req, input logic [64:0] act, input logic [64:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drives at the falling edge; the rising edge acts; the next falling edge samples
  task automatic step(input bit st, input logic [3:0] op, input logic [31:0] a,
                      input logic [31:0] b, input bit ld, input logic [63:0] lv);
    start_i = st; op_i = op; a_i = a; b_i = b;
    load_i = ld; load_hi_i = lv[63:32]; load_lo_i = lv[31:0];
    @(negedge clk);
    start_i = 1'b0; load_i = 1'b0;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [63:0] seeds [3] = '{64'h0000_0000_FFFF_FFFF, 64'hFFFF_FFFF_0000_0000,
                               64'h1357_9BDF_2468_ACE0};
    logic [63:0] exp;
    rst_n = 1'b0; start_i = 0; op_i = 0; a_i = 0; b_i = 0;
    load_i = 0; load_hi_i = 0; load_lo_i = 0;
    repeat (3) @(negedge clk);
    check("R1", {done_o, acc_hi_o, acc_lo_o}, 65'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", {done_o, acc_hi_o, acc_lo_o}, 65'd0);

    // Sweep: every op code over the operand grid and several accumulator seeds
    for (int op = 0; op < 16; op++) begin
      for (int s = 0; s < 3; s++) begin
        for (int i = 0; i < 8; i++) begin
          for (int j = 0; j < 8; j++) begin
            step(1'b0, 4'd0, 32'd0, 32'd0, 1'b1, seeds[s]);
            check("R10", {done_o, acc_hi_o, acc_lo_o}, {1'b0, seeds[s]});
            exp = model(4'(op), vals[i], vals[j], seeds[s]);
            step(1'b1, 4'(op), vals[i], vals[j], 1'b0, 64'd0);
            check(req_of(4'(op)), {1'b0, acc_hi_o, acc_lo_o}, {1'b0, exp});
            check("R9", {64'd0, done_o}, 65'd1);
          end
        end
      end
    end

    // Idle cycle: hold and no done
    step(1'b0, 4'd4, 32'h5, 32'h7, 1'b0, 64'd0);
    check("R12", {done_o, acc_hi_o, acc_lo_o}, {1'b0, exp});

    // Load and start together: load wins, no done
    step(1'b1, 4'd1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, 64'hDEAD_BEEF_0BAD_F00D);
    check("R10", {done_o, acc_hi_o, acc_lo_o}, {1'b0, 64'hDEAD_BEEF_0BAD_F00D});

    // Back-to-back accumulation: done stays high each cycle
    exp = 64'hDEAD_BEEF_0BAD_F00D;
    for (int k = 0; k < 4; k++) begin
      exp = model(4'd8, 32'h8000_8000, 32'h8000_8000, exp);
      start_i = 1'b1; op_i = 4'd8; a_i = 32'h8000_8000; b_i = 32'h8000_8000;
      @(negedge clk);
      check("R8", {done_o, acc_hi_o, acc_lo_o}, {1'b1, exp});
    end
    start_i = 1'b0;
    @(negedge clk);
    check("R9", {done_o, acc_hi_o, acc_lo_o}, {1'b0, exp});

    // Asynchronous reset in mid-run
    rst_n = 1'b0;
    #1;
    check("R1", {done_o, acc_hi_o, acc_lo_o}, 65'd0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule